// File: doc/BRIEF.md
# Snapshot Register Access Front-End

This block sits behind a byte-level bus transaction engine and in front of a small live timekeeping register file and a general-purpose byte memory. The transaction engine hands it a START strobe, a pointer-load strobe with an address, a write-byte strobe that stages a byte, an acknowledge event that commits the staged byte, and a read-byte request. The block keeps one auto-incrementing address pointer shared by reads and writes.

Time registers sit in the lowest part of the address space. Reads of that region never see the live counter directly: they come from a frozen copy. The copy is refreshed on each START and each time the pointer rolls back to address zero, so a multibyte read of the time fields returns one coherent instant while the counter keeps running. Host writes to time registers land in the live file on the acknowledge. Above the time region one reserved address follows, and everything from there up to the top of the byte address space is plain memory.

The live file contains a seconds field (address 00h) and a minutes field (address 01h), both BCD and counting 00 to 59, advanced by a one-per-second tick input. The remaining time addresses are plain storage.

Top module: `rtc_snap_frontend`

## Requirements
- R1: After reset the pointer is 00h, `rd_valid` is low, and every time register and every entry of the frozen copy reads as 00h.
- R2: A pointer load sets the pointer to `ptr_val`; each read request or write acknowledge without a load in the same cycle advances the pointer by one, including across the reserved address 13h to 14h.
- R3: Advancing from 12h, the last time address, takes the pointer to 00h.
- R4: Advancing from FFh takes the pointer to 00h, and that rollover also refreshes the frozen copy.
- R5: A START pulse copies all live time registers (values before that clock edge) into the frozen copy.
- R6: A pointer rollover to 00h caused by a read or write copies the live time registers into the frozen copy in the same way as R5.
- R7: Reads of addresses 00h to 12h return the frozen copy; live changes since the last refresh are not visible.
- R8: A write reaches its target only on `wr_ack`, using the byte staged by the most recent `wr_stb`; a `wr_stb` without `wr_ack` changes nothing.
- R9: Addresses 14h to FFh form a 236-byte read/write memory.
- R10: Address 13h is reserved: reads return 00h and writes are discarded.
- R11: Each `tick` advances the seconds field (00h) in BCD from 00 to 59; the step from 59 to 00 advances the minutes field (01h) in BCD from 00 to 59, also wrapping to 00.
- R12: When a host write to a time field and a tick update of that same field fall in one cycle, the host byte is kept and the tick's effect on that field (including a carry out of seconds) is dropped.
- R13: Read data appears on `rd_data` with `rd_valid` high exactly one cycle after `rd_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | One-cycle START event from the transaction engine |
| ptr_load | input | 1 | Load the address pointer from `ptr_val` |
| ptr_val | input | 8 | Pointer value to load |
| wr_stb | input | 1 | Stage `wr_byte` for the next acknowledge |
| wr_byte | input | 8 | Byte to stage |
| wr_ack | input | 1 | Commit the staged byte at the pointer and advance |
| rd_req | input | 1 | Read the byte at the pointer and advance |
| tick | input | 1 | One-second advance of the live counter |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | High the cycle after a read request |

## Verification
Two functions can land in one cycle: a tick that updates seconds (and possibly carries into minutes) and a host acknowledge that writes the same field. The bench provokes both pairings by first writing 59 into seconds, then issuing `tick` together with `wr_ack` while the pointer addresses seconds, and again while it addresses minutes. The outcome is judged after a START refresh by reading both fields back: the host byte must survive, and a carry must appear only when seconds itself was not overwritten.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

    localparam int ADDR_W    = 8;
    localparam int TIME_LAST = 18;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        AREA_TIME = 2'd0,
        AREA_RSVD = 2'd1,
        AREA_MEM  = 2'd2
    } area_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        byte_t             data;
    } host_wr_t;

    typedef struct packed {
        logic  carry;
        byte_t value;
    } bcd_step_t;

    // One BCD step inside 00..59; reports when it wrapped.
    function automatic bcd_step_t bcd_step59(input byte_t b);
        bcd_step_t r;
        if (b >= 8'h59) begin
            r.carry = 1'b1;
            r.value = 8'h00;
        end else if (b[3:0] >= 4'd9) begin
            r.carry = 1'b0;
            r.value = {b[7:4] + 4'd1, 4'h0};
        end else begin
            r.carry = 1'b0;
            r.value = b + 8'd1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_snap_ptr.sv
module rtc_snap_ptr #(
    parameter int AW   = 8,
    parameter int LAST = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    output logic [AW-1:0] ptr,
    output logic          wrap
);
    localparam logic [AW-1:0] LAST_A = AW'(LAST);
    localparam logic [AW-1:0] TOP_A  = '1;

    always_comb wrap = adv && !load && (ptr == LAST_A || ptr == TOP_A);

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= load_val;
        else if (adv)  ptr <= wrap ? '0 : ptr + AW'(1);
    end

    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        load |=> ptr == $past(load_val));
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && ptr < LAST_A) |=> ptr == $past(ptr) + AW'(1));
    a_r3_time_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && ptr == LAST_A) |=> ptr == '0);
    a_r4_top_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && ptr == TOP_A) |=> ptr == '0);
endmodule

// File: rtl/rtc_snap_live.sv
module rtc_snap_live
    import rtc_snap_pkg::*;
#(
    parameter int N = 19
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  host_wr_t            wr,
    output logic [N-1:0][7:0]   live
);
    logic [N-1:0][7:0] nxt;
    logic              sec_hit, min_hit;
    bcd_step_t         sec_s, min_s;

    always_comb begin
        sec_hit = wr.en && (wr.addr == ADDR_W'(0));
        min_hit = wr.en && (wr.addr == ADDR_W'(1));
        sec_s   = bcd_step59(live[0]);
        min_s   = bcd_step59(live[1]);
        nxt     = live;
        if (tick && !sec_hit) begin
            nxt[0] = sec_s.value;
            if (sec_s.carry && !min_hit) nxt[1] = min_s.value;
        end
        for (int i = 0; i < N; i++) begin
            if (wr.en && wr.addr == ADDR_W'(i)) nxt[i] = wr.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) live <= '0;
        else     live <= nxt;
    end

    a_r12_host_wins: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == ADDR_W'(0)) |=> live[0] == $past(wr.data));
    a_r11_sec_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr.en && live[0] == 8'h59) |=> live[0] == 8'h00);
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr.en) |=> $stable(live));
endmodule

// File: rtl/rtc_snap_shadow.sv
module rtc_snap_shadow #(
    parameter int N = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snap,
    input  logic [N-1:0][7:0] live,
    output logic [N-1:0][7:0] frozen
);
    always_ff @(posedge clk) begin
        if (rst)       frozen <= '0;
        else if (snap) frozen <= live;
    end

    a_r5_capture: assert property (@(posedge clk) disable iff (rst)
        snap |=> frozen == $past(live));
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !snap |=> $stable(frozen));
endmodule

// File: rtl/rtc_snap_sram.sv
module rtc_snap_sram #(
    parameter int AW    = 8,
    parameter int BASE  = 20,
    parameter int DEPTH = 236
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int IW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] woff, roff;
    logic [IW-1:0] widx, ridx;

    always_comb begin
        woff = waddr - AW'(BASE);
        roff = raddr - AW'(BASE);
        widx = IW'(woff);
        ridx = IW'(roff);
    end

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
        if (re) rdata <= mem[ridx];
    end
endmodule

// File: rtl/rtc_snap_frontend.sv
module rtc_snap_frontend
    import rtc_snap_pkg::*;
#(
    parameter int AW        = ADDR_W,
    parameter int TIME_TOP  = TIME_LAST
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_start,
    input  logic          ptr_load,
    input  logic [AW-1:0] ptr_val,
    input  logic          wr_stb,
    input  logic [7:0]    wr_byte,
    input  logic          wr_ack,
    input  logic          rd_req,
    input  logic          tick,
    output logic [7:0]    rd_data,
    output logic          rd_valid
);
    localparam int TIME_REGS = TIME_TOP + 1;
    localparam int RSVD_AT   = TIME_TOP + 1;
    localparam int MEM_BASE  = TIME_TOP + 2;
    localparam int MEM_DEPTH = (1 << AW) - MEM_BASE;

    logic [AW-1:0]              ptr;
    logic                       wrap, adv, snap;
    area_e                      area, rd_area_q;
    byte_t                      staged_q, time_q, mem_rdata, frozen_byte;
    host_wr_t                   time_wr;
    logic [TIME_REGS-1:0][7:0]  live, frozen;

    always_comb begin
        if (ptr <= AW'(TIME_TOP))     area = AREA_TIME;
        else if (ptr == AW'(RSVD_AT)) area = AREA_RSVD;
        else                          area = AREA_MEM;
        adv  = rd_req || wr_ack;
        snap = bus_start || wrap;
        time_wr.en   = wr_ack && (area == AREA_TIME);
        time_wr.addr = ADDR_W'(ptr);
        time_wr.data = staged_q;
        frozen_byte  = 8'h00;
        for (int i = 0; i < TIME_REGS; i++) begin
            if (ptr == AW'(i)) frozen_byte = frozen[i];
        end
    end

    rtc_snap_ptr #(.AW(AW), .LAST(TIME_TOP)) u_ptr (
        .clk(clk), .rst(rst), .load(ptr_load), .load_val(ptr_val),
        .adv(adv), .ptr(ptr), .wrap(wrap)
    );

    rtc_snap_live #(.N(TIME_REGS)) u_live (
        .clk(clk), .rst(rst), .tick(tick), .wr(time_wr), .live(live)
    );

    rtc_snap_shadow #(.N(TIME_REGS)) u_shadow (
        .clk(clk), .rst(rst), .snap(snap), .live(live), .frozen(frozen)
    );

    rtc_snap_sram #(.AW(AW), .BASE(MEM_BASE), .DEPTH(MEM_DEPTH)) u_sram (
        .clk(clk),
        .we(wr_ack && area == AREA_MEM), .waddr(ptr), .wdata(staged_q),
        .re(rd_req && area == AREA_MEM), .raddr(ptr), .rdata(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q  <= 8'h00;
            time_q    <= 8'h00;
            rd_area_q <= AREA_RSVD;
            rd_valid  <= 1'b0;
        end else begin
            if (wr_stb) staged_q <= wr_byte;
            rd_valid <= rd_req;
            if (rd_req) begin
                rd_area_q <= area;
                time_q    <= frozen_byte;
            end
        end
    end

    always_comb begin
        case (rd_area_q)
            AREA_TIME: rd_data = time_q;
            AREA_MEM:  rd_data = mem_rdata;
            default:   rd_data = 8'h00;
        endcase
    end

    a_r13_rd_valid: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);
    a_r10_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_req && ptr == AW'(RSVD_AT)) |=> rd_data == 8'h00);
    a_r6_wrap_snap: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !ptr_load && ptr == AW'(TIME_TOP)) |=> frozen == $past(live));
    a_r7_time_read: assert property (@(posedge clk) disable iff (rst)
        (rd_req && ptr == AW'(0)) |=> rd_data == $past(frozen[0]));
endmodule

// File: tb/rtc_snap_frontend_test.sv
module rtc_snap_frontend_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_start = 0, ptr_load = 0, wr_stb = 0, wr_ack = 0, rd_req = 0, tick = 0;
    logic [7:0] ptr_val = 0, wr_byte = 0;
    logic [7:0] rd_data;
    logic       rd_valid;

    int checks = 0, fails = 0;
    bit done = 0;

    rtc_snap_frontend uut (
        .clk(clk), .rst(rst), .bus_start(bus_start), .ptr_load(ptr_load),
        .ptr_val(ptr_val), .wr_stb(wr_stb), .wr_byte(wr_byte), .wr_ack(wr_ack),
        .rd_req(rd_req), .tick(tick), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    int m_live [19];
    int m_frz  [19];
    int m_mem  [256];
    int m_ptr, m_staged, e_data;
    bit e_valid;

    function automatic int bcd_next(input int b, output bit carry);
        int d;
        d = (b / 16) * 10 + (b % 16);
        d = (d + 1) % 60;
        carry = (d == 0);
        return (d / 10) * 16 + (d % 10);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_live[i]) begin m_live[i] = 0; m_frz[i] = 0; end
            m_ptr = 0; m_staged = 0; e_valid = 0; e_data = 0;
        end else begin
            int  old_live [19];
            bit  c, wrapping, wsec, wmin;
            int  nv;
            old_live = m_live;
            e_valid = rd_req;
            if (rd_req) begin
                if (m_ptr <= 18)      e_data = m_frz[m_ptr];
                else if (m_ptr == 19) e_data = 0;
                else                  e_data = m_mem[m_ptr];
            end
            wrapping = (rd_req || wr_ack) && !ptr_load && (m_ptr == 18 || m_ptr == 255);
            wsec = wr_ack && m_ptr == 0;
            wmin = wr_ack && m_ptr == 1;
            if (tick && !wsec) begin
                m_live[0] = bcd_next(old_live[0], c);
                if (c && !wmin) m_live[1] = bcd_next(old_live[1], c);
            end
            if (wr_ack && m_ptr <= 18) m_live[m_ptr] = m_staged;
            if (wr_ack && m_ptr >= 20) m_mem[m_ptr] = m_staged;
            if (bus_start || wrapping) m_frz = old_live;
            if (wr_stb) m_staged = wr_byte;
            if (ptr_load) m_ptr = ptr_val;
            else if (rd_req || wr_ack) begin
                nv = wrapping ? 0 : m_ptr + 1;
                m_ptr = nv;
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (rd_valid !== e_valid || (e_valid && rd_data !== e_data)) begin
                fails++;
                $display("FAIL R13 model: valid=%0d data=%02h expected valid=%0d data=%02h",
                         rd_valid, rd_data, e_valid, e_data[7:0]);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        bus_start = 0; ptr_load = 0; wr_stb = 0; wr_ack = 0; rd_req = 0; tick = 0;
    endtask

    task automatic op_start();
        @(negedge clk); bus_start = 1; @(negedge clk); idle_all();
    endtask
    task automatic op_load(input int a);
        @(negedge clk); ptr_load = 1; ptr_val = 8'(a); @(negedge clk); idle_all();
    endtask
    task automatic op_tick();
        @(negedge clk); tick = 1; @(negedge clk); idle_all();
    endtask
    task automatic op_stage(input int v);
        @(negedge clk); wr_stb = 1; wr_byte = 8'(v); @(negedge clk); idle_all();
    endtask
    task automatic op_write(input int v);
        op_stage(v);
        @(negedge clk); wr_ack = 1; @(negedge clk); idle_all();
    endtask
    task automatic op_tick_ack();
        @(negedge clk); tick = 1; wr_ack = 1; @(negedge clk); idle_all();
    endtask
    task automatic op_read(input string tag, input int exp);
        @(negedge clk); rd_req = 1;
        @(negedge clk); idle_all();
        check(tag, rd_valid ? int'(rd_data) : -1, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 rd_valid after reset", int'(rd_valid), 0);
        op_start(); op_load(0);
        op_read("R1 reset time value", 8'h00);

        op_load(0); op_write(8'h58); op_write(8'h59); op_write(8'h23);
        op_start(); op_load(0);
        op_read("R5 seconds after START", 8'h58);
        op_read("R8 minutes written on ack", 8'h59);
        op_read("R2 third byte advanced", 8'h23);

        op_tick(); op_tick();
        op_load(0);
        op_read("R7 frozen copy unchanged by ticks", 8'h58);
        op_start(); op_load(0);
        op_read("R11 seconds 59 to 00", 8'h00);
        op_read("R11 minutes carry 59 to 00", 8'h00);

        op_tick();
        op_load(8'h11);
        op_read("R7 unwritten time reg", 8'h00);
        op_read("R3 last time reg", 8'h00);
        op_read("R6 refresh on wrap after 12h", 8'h01);

        op_load(8'h14); op_write(8'hAA); op_write(8'hBB);
        op_tick();
        op_load(8'hFE); op_write(8'h11); op_write(8'hCC);
        op_read("R4 refresh on wrap after FFh", 8'h02);
        op_load(8'h14);
        op_read("R9 memory 14h", 8'hAA);
        op_read("R9 memory 15h", 8'hBB);
        op_load(8'hFE);
        op_read("R9 memory FEh", 8'h11);
        op_read("R9 memory FFh", 8'hCC);

        op_load(8'h13); op_write(8'h55);
        op_read("R2 advance past reserved", 8'hAA);
        op_load(8'h13);
        op_read("R10 reserved reads zero", 8'h00);

        op_load(8'h20); op_write(8'h01);
        op_load(8'h20); op_stage(8'h77);
        op_read("R8 stage without ack ignored", 8'h01);

        op_load(0); op_write(8'h59);
        op_load(0); op_stage(8'h30); op_tick_ack();
        op_start(); op_load(0);
        op_read("R12 host beats tick on seconds", 8'h30);
        op_read("R12 no carry when seconds written", 8'h00);

        op_load(0); op_write(8'h59);
        op_stage(8'h42); op_tick_ack();
        op_start(); op_load(0);
        op_read("R12 tick still wraps seconds", 8'h00);
        op_read("R12 host beats carry on minutes", 8'h42);

        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule